// File: doc/BRIEF.md
# Sound-CPU I/O Page Decoder with Boot-ROM Overlay

This block sits between a small sound CPU and the memory it shares with an audio signal processor. It decodes the CPU's 16-bit address bus. The sixteen addresses 0x00F0 to 0x00FF form an I/O page. Eight of them (0x00F0 to 0x00F7) are served by registers held in this block, and the other eight are passed to RAM. Every other address is passed to the external RAM port. The exception is the top 64 bytes, where a small boot ROM can be laid over RAM for reads.

The block holds a control register with three jobs. It enables three timers in a separate timer block, it switches the ROM overlay on or off, and it can zero the four CPU-to-host port registers in pairs. The block also holds an index latch. Through that latch, one data address reaches a 128-entry register file inside the signal processor. Accesses through the data address with an out-of-range index are filtered out.

Reads are combinational. The read data follows the address in the same cycle. Writes take effect at the clock edge that ends the write cycle.

Top module: `snd_io_page`

## Requirements
- R1: After reset the overlay is on, the DSP index is 0x00, all four ports are 0x00 and `timerEn` is 0.
- R2: For any address below 0x00F0, or from 0x0100 to 0xFFBF, a write drives `ramWrEn` with `ramAddr`/`ramWrData` equal to the CPU address and data, and a read returns `ramRdData`.
- R3: While the overlay is on, a read from 0xFFC0+k (k = 0..63) returns the ROM byte ((4*k+1) mod 256) XOR 0x3C. While it is off, such a read returns RAM data.
- R4: A write to 0xFFC0..0xFFFF always drives the RAM write, whatever the overlay state, so that the data can be read back once the overlay is off.
- R5: A write to 0x00F1 loads its bits 2:0 into `timerEn` (bit 0 is timer 0) from the next cycle, and its bit 7 sets the overlay on (1) or off (0).
- R6: A write to 0x00F1 with bit 4 set zeroes ports 0x00F4 and 0x00F5, and with bit 5 set zeroes ports 0x00F6 and 0x00F7. A read in the next cycle returns 0x00. When a clear bit is 0, its pair is left unchanged.
- R7: A write to 0x00F4..0x00F7 loads that port, and a read returns the value. `hostPorts` carries 0x00F4 in bits 7:0, 0x00F5 in bits 15:8, 0x00F6 in bits 23:16 and 0x00F7 in bits 31:24.
- R8: A read of 0x00F0 or 0x00F1 returns 0x00. A write to 0x00F0..0x00F7 never raises `ramWrEn`.
- R9: 0x00F2 is a readable and writable 8-bit index latch, and `dspAddr` always equals its bits 6:0.
- R10: A write to 0x00F3 raises `dspWrEn` only when index bit 7 is 0. A read of 0x00F3 returns `dspRdData`, which is addressed by the index masked to 7 bits.
- R11: Addresses 0x00F8..0x00FF behave as plain RAM for reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrEn | input | 1 | CPU write strobe for this cycle |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data, combinational from address |
| ramAddr | output | 16 | RAM address |
| ramWrEn | output | 1 | RAM write enable |
| ramWrData | output | 8 | RAM write data |
| ramRdData | input | 8 | RAM read data, combinational |
| dspAddr | output | 7 | DSP register index |
| dspWrEn | output | 1 | DSP register write enable |
| dspWrData | output | 8 | DSP register write data |
| dspRdData | input | 8 | DSP register read data |
| timerEn | output | 3 | Timer enable bits to the timer block |
| hostPorts | output | 32 | Four port registers, packed |

## Verification
The bench targets the edges of the ROM window and the write-through rule inside it. If the overlay captured writes, the data written under the ROM would be missing once the overlay is turned off. If the window boundary were off by one, address 0xFFBF would return ROM data, or 0xFFC0 would return RAM data.

The bench checks port clearing in each pair separately, with both pairs together, and with neither. A decoder that mixed up the pairs, or that cleared on every control write, leaves the wrong bytes on `hostPorts`.

The bench also sets index bit 7 and writes through 0x00F3. A block that did not filter the write would corrupt DSP register (index & 0x7F), and a later read through the masked index would expose it. Finally, it writes every local register address while watching `ramWrEn`, which catches a RAM page that is shadowing the local registers.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [2:0] {
    RD_RAM,
    RD_ROM,
    RD_ZERO,
    RD_INDEX,
    RD_DSP,
    RD_PORT
  } rdSel_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic       wrCtrl;
    logic       wrIndex;
    logic       wrDsp;
    logic       wrPort;
    logic [1:0] portIdx;
    logic       ramWr;
    rdSel_e     rdSel;
  } ioStrobe_t;

  // Boot image is generated rather than stored as a table
  function automatic logic [7:0] romByte(input logic [5:0] k);
    return {k, 2'b01} ^ 8'h3C;
  endfunction

endpackage

// File: rtl/sio_decode.sv
module sio_decode
  import sio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 64,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h00F0
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic              romEn,
  output ioStrobe_t         stb
);

  localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((2 ** ADDR_W) - ROM_BYTES);

  logic inPage, inLocal, inRom;

  always_comb begin
    inPage = (cpuAddr[ADDR_W-1:4] == IO_BASE[ADDR_W-1:4]);
    inLocal = inPage && !cpuAddr[3];
    inRom = (cpuAddr >= ROM_BASE);

    stb = '0;
    stb.rdSel = RD_RAM;
    stb.portIdx = cpuAddr[1:0];
    stb.ramWr = cpuWrEn && !inLocal;

    if (inLocal) begin
      if (cpuAddr[2]) begin
        stb.rdSel = RD_PORT;
        stb.wrPort = cpuWrEn;
      end else begin
        unique case (cpuAddr[1:0])
          2'd0: stb.rdSel = RD_ZERO;
          2'd1: begin
            stb.rdSel = RD_ZERO;
            stb.wrCtrl = cpuWrEn;
          end
          2'd2: begin
            stb.rdSel = RD_INDEX;
            stb.wrIndex = cpuWrEn;
          end
          default: begin
            stb.rdSel = RD_DSP;
            stb.wrDsp = cpuWrEn;
          end
        endcase
      end
    end else if (inRom && romEn) begin
      stb.rdSel = RD_ROM;
    end
  end

endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_TIMERS = 3,
  parameter int NUM_PORTS  = 4,
  parameter int IDX_W      = 7,
  parameter int CLR_BIT    = 4,
  parameter int ROM_EN_BIT = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ioStrobe_t                   stb,
  input  logic [5:0]                  romOfs,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [DATA_W-1:0]           ramRdData,
  input  logic [DATA_W-1:0]           dspRdData,
  output logic [DATA_W-1:0]           rdData,
  output logic                        romEn,
  output logic [IDX_W-1:0]            dspAddr,
  output logic                        dspWrEn,
  output logic [NUM_TIMERS-1:0]       timerEn,
  output logic [NUM_PORTS*DATA_W-1:0] hostPorts
);

  logic [DATA_W-1:0] index;
  logic [DATA_W-1:0] portReg [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romEn   <= 1'b1;
      timerEn <= '0;
      index   <= '0;
    end else begin
      if (stb.wrCtrl) begin
        romEn   <= wrData[ROM_EN_BIT];
        timerEn <= wrData[NUM_TIMERS-1:0];
      end
      if (stb.wrIndex) index <= wrData;
    end
  end

  // One register per port; each pair shares a clear bit
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        portReg[p] <= '0;
      end else if (stb.wrCtrl && wrData[CLR_BIT + p/2]) begin
        portReg[p] <= '0;
      end else if (stb.wrPort && stb.portIdx == 2'(p)) begin
        portReg[p] <= wrData;
      end
    end
    assign hostPorts[p*DATA_W +: DATA_W] = portReg[p];
  end

  assign dspAddr = index[IDX_W-1:0];
  assign dspWrEn = stb.wrDsp && !index[IDX_W];

  always_comb begin
    unique case (stb.rdSel)
      RD_ROM:   rdData = romByte(romOfs);
      RD_ZERO:  rdData = '0;
      RD_INDEX: rdData = index;
      RD_DSP:   rdData = dspRdData;
      RD_PORT:  rdData = portReg[stb.portIdx];
      default:  rdData = ramRdData;
    endcase
  end

endmodule

// File: rtl/snd_io_page.sv
module snd_io_page
  import sio_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_BYTES  = 64,
  parameter int NUM_TIMERS = 3,
  parameter int NUM_PORTS  = 4,
  parameter int IDX_W      = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           cpuAddr,
  input  logic                        cpuWrEn,
  input  logic [DATA_W-1:0]           cpuWrData,
  output logic [DATA_W-1:0]           cpuRdData,
  output logic [ADDR_W-1:0]           ramAddr,
  output logic                        ramWrEn,
  output logic [DATA_W-1:0]           ramWrData,
  input  logic [DATA_W-1:0]           ramRdData,
  output logic [IDX_W-1:0]            dspAddr,
  output logic                        dspWrEn,
  output logic [DATA_W-1:0]           dspWrData,
  input  logic [DATA_W-1:0]           dspRdData,
  output logic [NUM_TIMERS-1:0]       timerEn,
  output logic [NUM_PORTS*DATA_W-1:0] hostPorts
);

  ioStrobe_t stb;
  logic      romEn;

  sio_decode #(
    .ADDR_W   (ADDR_W),
    .ROM_BYTES(ROM_BYTES)
  ) u_decode (
    .cpuAddr(cpuAddr),
    .cpuWrEn(cpuWrEn),
    .romEn  (romEn),
    .stb    (stb)
  );

  sio_regs #(
    .DATA_W    (DATA_W),
    .NUM_TIMERS(NUM_TIMERS),
    .NUM_PORTS (NUM_PORTS),
    .IDX_W     (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .romOfs   (cpuAddr[5:0]),
    .wrData   (cpuWrData),
    .ramRdData(ramRdData),
    .dspRdData(dspRdData),
    .rdData   (cpuRdData),
    .romEn    (romEn),
    .dspAddr  (dspAddr),
    .dspWrEn  (dspWrEn),
    .timerEn  (timerEn),
    .hostPorts(hostPorts)
  );

  assign ramAddr   = cpuAddr;
  assign ramWrEn   = stb.ramWr;
  assign ramWrData = cpuWrData;
  assign dspWrData = cpuWrData;

endmodule

// File: rtl/snd_io_page_chk.sv
module snd_io_page_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cpuWrEn,
  input logic [7:0]  cpuWrData,
  input logic [7:0]  cpuRdData,
  input logic        ramWrEn,
  input logic        dspWrEn,
  input logic [2:0]  timerEn,
  input logic [31:0] hostPorts
);

  logic isLocal;
  assign isLocal = (cpuAddr[15:3] == 13'h001E);

  AST_ROM_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr >= 16'hFFC0) |-> ramWrEn);  // R4

  AST_LOCAL_NO_RAM_WR: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && isLocal) |-> !ramWrEn);  // R8

  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr == 16'h00F0 || cpuAddr == 16'h00F1) |-> cpuRdData == 8'h00);  // R8

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr == 16'h00F1) |=> timerEn == $past(cpuWrData[2:0]));  // R5

  AST_CLEAR_LOW_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr == 16'h00F1 && cpuWrData[4]) |=> hostPorts[15:0] == 16'h0);  // R6

  AST_CLEAR_HIGH_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr == 16'h00F1 && cpuWrData[5]) |=> hostPorts[31:16] == 16'h0);  // R6

  AST_DSP_WR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    dspWrEn |-> (cpuWrEn && cpuAddr == 16'h00F3));  // R10

endmodule

bind snd_io_page snd_io_page_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAddr  (cpuAddr),
  .cpuWrEn  (cpuWrEn),
  .cpuWrData(cpuWrData),
  .cpuRdData(cpuRdData),
  .ramWrEn  (ramWrEn),
  .dspWrEn  (dspWrEn),
  .timerEn  (timerEn),
  .hostPorts(hostPorts)
);

// File: tb/snd_io_page_bench.sv
module snd_io_page_bench;

  localparam int K_RD = 0, K_RAMWE = 1, K_DSPWE = 2, K_TIMER = 3, K_PORTS = 4;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWrEn = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic [15:0] ramAddr;
  logic        ramWrEn;
  logic [7:0]  ramWrData;
  logic [7:0]  ramRdData;
  logic [6:0]  dspAddr;
  logic        dspWrEn;
  logic [7:0]  dspWrData;
  logic [7:0]  dspRdData;
  logic [2:0]  timerEn;
  logic [31:0] hostPorts;

  // Small RAM model indexed by the low address byte; tests use distinct low bytes
  logic [7:0] ramModel [256];
  logic [7:0] dspRegs [128];

  item_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  snd_io_page u_snd_io_page (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .ramAddr(ramAddr),
    .ramWrEn(ramWrEn), .ramWrData(ramWrData), .ramRdData(ramRdData),
    .dspAddr(dspAddr), .dspWrEn(dspWrEn), .dspWrData(dspWrData),
    .dspRdData(dspRdData), .timerEn(timerEn), .hostPorts(hostPorts)
  );

  assign ramRdData = ramModel[ramAddr[7:0]];
  assign dspRdData = dspRegs[dspAddr];

  always @(posedge clk) begin
    if (ramWrEn) ramModel[ramAddr[7:0]] <= ramWrData;
    if (dspWrEn) dspRegs[dspAddr] <= dspWrData;
  end

  // Monitor: pops every expectation queued for this cycle
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = {24'h0, cpuRdData};
        K_RAMWE: act = {31'h0, ramWrEn};
        K_DSPWE: act = {31'h0, dspWrEn};
        K_TIMER: act = {29'h0, timerEn};
        default: act = hostPorts;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                 it.req, it.kind, cpuAddr, act, it.exp);
      end
    end
  end

  function automatic logic [7:0] bootByte(input int k);
    return 8'((4 * k + 1) % 256) ^ 8'h3C;
  endfunction

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind;
    it.exp = exp;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    tick();
    cpuWrEn = 1'b0;
  endtask

  task automatic wrChk(input logic [15:0] a, input logic [7:0] d,
                       input logic expRam, input logic expDsp, input string req);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    push(K_RAMWE, {31'h0, expRam}, req);
    push(K_DSPWE, {31'h0, expDsp}, req);
    tick();
    cpuWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [7:0] exp, input string req);
    cpuAddr = a; cpuWrEn = 1'b0;
    push(K_RD, {24'h0, exp}, req);
    tick();
  endtask

  task automatic stateChk(input int kind, input logic [31:0] exp, input string req);
    cpuAddr = 16'h0300; cpuWrEn = 1'b0;
    push(kind, exp, req);
    tick();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ramModel[i] = 8'h00;
    for (int i = 0; i < 128; i++) dspRegs[i] = 8'h00;
    repeat (3) tick();
    rstN = 1'b1;

    // R1 reset state
    stateChk(K_TIMER, 32'h0, "R1");
    stateChk(K_PORTS, 32'h0, "R1");
    rdChk(16'h00F2, 8'h00, "R1");
    rdChk(16'hFFC0, bootByte(0), "R1");

    // R2 plain RAM
    wrChk(16'h1234, 8'h5A, 1'b1, 1'b0, "R2");
    rdChk(16'h1234, 8'h5A, "R2");
    wrChk(16'h00EF, 8'h11, 1'b1, 1'b0, "R2");
    rdChk(16'h00EF, 8'h11, "R2");
    wrChk(16'hFFBF, 8'h6E, 1'b1, 1'b0, "R2");
    rdChk(16'hFFBF, 8'h6E, "R2");

    // R3/R4 overlay and write-through
    wrChk(16'hFFC0, 8'h77, 1'b1, 1'b0, "R4");
    rdChk(16'hFFC0, bootByte(0), "R3");
    rdChk(16'hFFFF, bootByte(63), "R3");
    rdChk(16'hFFD5, bootByte(21), "R3");

    // R5 control: timers and overlay off
    wr(16'h00F1, 8'h05);
    stateChk(K_TIMER, 32'h5, "R5");
    rdChk(16'hFFC0, 8'h77, "R4");
    rdChk(16'h00F1, 8'h00, "R8");
    wr(16'h00F1, 8'h83);
    stateChk(K_TIMER, 32'h3, "R5");
    rdChk(16'hFFC0, bootByte(0), "R5");

    // R7/R8 ports
    wrChk(16'h00F4, 8'h11, 1'b0, 1'b0, "R8");
    wrChk(16'h00F5, 8'h22, 1'b0, 1'b0, "R8");
    wrChk(16'h00F6, 8'h33, 1'b0, 1'b0, "R8");
    wrChk(16'h00F7, 8'h44, 1'b0, 1'b0, "R8");
    rdChk(16'h00F5, 8'h22, "R7");
    rdChk(16'h00F7, 8'h44, "R7");
    stateChk(K_PORTS, 32'h44332211, "R7");

    // R6 clears
    wr(16'h00F1, 8'h90);
    rdChk(16'h00F4, 8'h00, "R6");
    stateChk(K_PORTS, 32'h44330000, "R6");
    wr(16'h00F4, 8'h11);
    wr(16'h00F5, 8'h22);
    wr(16'h00F1, 8'hA0);
    rdChk(16'h00F7, 8'h00, "R6");
    stateChk(K_PORTS, 32'h00002211, "R6");
    wr(16'h00F6, 8'h33);
    wr(16'h00F7, 8'h44);
    wr(16'h00F1, 8'h80);
    stateChk(K_PORTS, 32'h44332211, "R6");
    wr(16'h00F1, 8'hB0);
    stateChk(K_PORTS, 32'h00000000, "R6");

    // R9/R10 DSP window
    wr(16'h00F2, 8'h15);
    rdChk(16'h00F2, 8'h15, "R9");
    wrChk(16'h00F3, 8'h99, 1'b0, 1'b1, "R10");
    rdChk(16'h00F3, 8'h99, "R10");
    wr(16'h00F2, 8'h95);
    rdChk(16'h00F2, 8'h95, "R9");
    wrChk(16'h00F3, 8'h42, 1'b0, 1'b0, "R10");
    rdChk(16'h00F3, 8'h99, "R10");

    // R8 test register
    wrChk(16'h00F0, 8'h12, 1'b0, 1'b0, "R8");
    rdChk(16'h00F0, 8'h00, "R8");

    // R11 upper half of the page is RAM
    wrChk(16'h00F8, 8'hAB, 1'b1, 1'b0, "R11");
    wrChk(16'h00F9, 8'hCD, 1'b1, 1'b0, "R11");
    wrChk(16'h00FA, 8'h3E, 1'b1, 1'b0, "R11");
    rdChk(16'h00F8, 8'hAB, "R11");
    rdChk(16'h00F9, 8'hCD, "R11");
    rdChk(16'h00FA, 8'h3E, "R11");

    tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule